// File: doc/BRIEF.md
# Polled I2C Master Byte Engine

This block is a single-master I2C transmitter that software runs through a small register set. The register set has a three-bit control register (enable, start request, stop request), a transmit data port and two status flags: operation complete and acknowledge received. Every bus operation begins with one write to the transmit data port. The control bits at the moment of that write decide what the engine does. It can send a start condition and then the byte, send the byte alone on a bus it already holds, or send a stop condition and ignore the data.

Software polls the complete flag between operations. A byte write is built as start plus address, then the word address, then the data, then a stop. A page write is built the same way with several data bytes before the stop. The acknowledge flag reports after each byte whether the slave accepted it. Both bus lines are open-drain. The block outputs drive-low enables and reads back the level of the data line. Bit timing is derived from the system clock: each SCL bit period is split into four quarter-phases of `QDIV` system clocks.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the complete flag is 1, the acknowledge flag is 0, the control register reads 0 and neither bus line is driven low.
- R2: The control register bits are bit 0 enable, bit 1 start request and bit 2 stop request. A transmit write is accepted only when all of the following hold: the engine is idle, the complete flag is 1, enable is 1, and start is set, stop is set or the bus is already held. An accepted write clears the complete flag on the next clock edge. With start set, the engine produces a start condition, or a repeated start if it already holds the bus, and then the byte.
- R3: With stop set and start clear, the written data is ignored. On a held bus the engine produces one stop condition and then releases both lines. On a bus it does not hold, it completes without driving either line.
- R4: With neither start nor stop set on a held bus, exactly one byte is sent. Afterwards the engine keeps SCL low and releases SDA, so further bytes can follow without a new start.
- R5: The acknowledge flag is 1 when SDA reads low in the middle of the high half of the ninth SCL pulse of the last byte, and 0 otherwise.
- R6: The complete flag returns to 1 exactly 40 quarter-phases after acceptance for a start plus byte, 36 for a byte alone and 4 for a stop.
- R7: Transmit writes are ignored when any of the following holds: the engine is busy, enable is clear, or the write would send a plain byte on a bus the engine does not hold. An ignored write leaves the complete flag, the bus lines and the operation in progress unchanged.
- R8: If start and stop are both set, start wins. When an operation finishes, its own request bit clears: start after the start-plus-byte, stop after the stop. The other bits keep their values.
- R9: Bytes go out most significant bit first. SDA changes while SCL is high only to form a start or a stop condition.
- R10: Clearing enable while idle on a held bus releases both lines without producing a stop condition, and the bus is then no longer held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_din | input | 3 | Control write data: {stop, start, enable} |
| ctl_q | output | 3 | Control register contents: {stop, start, enable} |
| tx_we | input | 1 | Transmit data write strobe, triggers an operation |
| tx_din | input | 8 | Transmit data byte |
| st_done | output | 1 | Operation complete flag |
| st_ack | output | 1 | Acknowledge received on the last byte |
| scl_pull_low | output | 1 | Drive SCL low when 1, release when 0 |
| sda_pull_low | output | 1 | Drive SDA low when 1, release when 0 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Each result has a fixed due cycle, counted from the clock edge that accepts a transmit write. The complete flag must fall on that edge. It must return exactly 160, 144 or 16 cycles later with the default four-cycle quarter-phase. The bench samples it one cycle before and on the due edge. The acknowledge flag, the received byte and the start and stop event counts come from a bus-level slave model. They are compared only after the complete flag has returned, and ignored writes are judged a few cycles after they are issued. All sampling is done on the falling clock edge, half a cycle after the register update it observes.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [2:0] ctl_din,
  output logic [2:0] ctl_q,
  input  logic       tx_we,
  input  logic [7:0] tx_din,
  output logic       st_done,
  output logic       st_ack,
  output logic       scl_pull_low,
  output logic       sda_pull_low,
  input  logic       sda_in
);
  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} state_t;

  state_t        st;
  logic [QW-1:0] qcnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic          owned, en, go, halt;

  wire tick   = (qcnt == QW'(QDIV - 1));
  wire last_q = tick && (ph == 2'd3);
  wire accept = tx_we && st_done && en && (go || halt || owned);

  assign ctl_q = {halt, go, en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      qcnt    <= '0;
      ph      <= 2'd0;
      bitn    <= 4'd0;
      sh      <= 8'd0;
      owned   <= 1'b0;
      en      <= 1'b0;
      go      <= 1'b0;
      halt    <= 1'b0;
      st_done <= 1'b1;
      st_ack  <= 1'b0;
    end else begin
      if (ctl_we) {halt, go, en} <= ctl_din;
      if (st == S_IDLE) begin
        qcnt <= '0;
        ph   <= 2'd0;
        if (accept) begin
          st_done <= 1'b0;
          sh      <= tx_din;
          bitn    <= 4'd0;
          if (go)        st <= S_START;
          else if (halt) st <= S_STOP;
          else           st <= S_BIT;
        end else if (!en) begin
          owned <= 1'b0;
        end
      end else begin
        qcnt <= tick ? '0 : qcnt + 1'b1;
        if (tick) ph <= ph + 2'd1;
        if (st == S_BIT && tick && ph == 2'd1 && bitn == 4'd8)
          st_ack <= ~sda_in;
        if (last_q) begin
          case (st)
            S_START: begin
              st    <= S_BIT;
              owned <= 1'b1;
            end
            S_BIT: begin
              if (bitn == 4'd8) begin
                st      <= S_IDLE;
                st_done <= 1'b1;
                if (!ctl_we) go <= 1'b0;
              end else begin
                bitn <= bitn + 4'd1;
                sh   <= {sh[6:0], 1'b0};
              end
            end
            S_STOP: begin
              st      <= S_IDLE;
              st_done <= 1'b1;
              owned   <= 1'b0;
              if (!ctl_we) halt <= 1'b0;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_pull_low = 1'b0;
    sda_pull_low = 1'b0;
    case (st)
      S_IDLE:  scl_pull_low = owned;
      S_START: begin
        scl_pull_low = (ph == 2'd0) ? owned : (ph == 2'd3);
        sda_pull_low = ph[1];
      end
      S_BIT: begin
        scl_pull_low = (ph == 2'd0) || (ph == 2'd3);
        sda_pull_low = (bitn != 4'd8) && !sh[7];
      end
      S_STOP: begin
        scl_pull_low = owned && (ph == 2'd0);
        sda_pull_low = owned && !ph[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic       tx_we,
  input logic [2:0] ctl_q,
  input logic       st_done,
  input logic       st_ack,
  input logic       scl_pull_low,
  input logic       sda_pull_low
);
  p_accept_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && tx_we && ctl_q[0] && (ctl_q[1] || ctl_q[2]) |=> !st_done);

  p_stop_edge_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_low) && !scl_pull_low && !$past(scl_pull_low) |-> ctl_q[2]);

  p_ack_moves_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(st_ack) |-> !st_done);

  p_idle_stays_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && !tx_we |=> st_done);

  p_disabled_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && tx_we && !ctl_q[0] |=> st_done);

  p_start_bit_clears_on_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[1]) && !$past(ctl_we) |-> $rose(st_done));

  p_start_edge_needs_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) && !scl_pull_low && !$past(scl_pull_low) |-> ctl_q[1]);

  p_free_bus_sda_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && !scl_pull_low |-> !sda_pull_low);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (.*);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_din = 3'd0;
  logic [2:0] ctl_q;
  logic       tx_we = 1'b0;
  logic [7:0] tx_din = 8'd0;
  logic       st_done, st_ack, scl_pull_low, sda_pull_low;
  logic       slv_low = 1'b0;
  wire        scl_line = ~scl_pull_low;
  wire        sda_line = ~(sda_pull_low | slv_low);

  int total = 0, bad = 0;
  int nstarts = 0, nstops = 0, nbytes = 0, bitcnt = 0;
  bit ackphase = 1'b0, ack_want = 1'b1;
  logic [7:0] rx_sh = 8'd0, last_byte = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master #(.QDIV(Q)) i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_din(ctl_din), .ctl_q(ctl_q),
    .tx_we(tx_we), .tx_din(tx_din), .st_done(st_done), .st_ack(st_ack),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low), .sda_in(sda_line));

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    nstarts++; bitcnt = 0; ackphase = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) nstops++;
  always @(posedge scl_line) if (bitcnt < 8) begin
    rx_sh = {rx_sh[6:0], sda_line}; bitcnt++;
  end
  always @(negedge scl_line) begin
    if (ackphase) begin
      slv_low = 1'b0; ackphase = 1'b0; bitcnt = 0; last_byte = rx_sh; nbytes++;
    end else if (bitcnt == 8) begin
      slv_low = ack_want; ackphase = 1'b1;
    end
  end

  function automatic int exp_quarters(bit start, bit stop);
    if (start) return 40;
    if (stop) return 4;
    return 36;
  endfunction

  function automatic bit exp_ack(bit want);
    return want;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_din = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_tx(logic [7:0] d);
    @(negedge clk); tx_we = 1'b1; tx_din = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  // accepted operation: checks done timing (R2, R6), optional busy poke (R7)
  task automatic run_op(logic [7:0] d, int nq, bit poke);
    int n;
    n = nq * Q;
    wr_tx(d);
    chk(st_done == 1'b0, "R2 done cleared", int'(st_done), 0);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      if (poke && k == 6) begin tx_we = 1'b1; tx_din = ~d; end
      else tx_we = 1'b0;
    end
    chk(st_done == 1'b0, "R6 done early", int'(st_done), 0);
    @(negedge clk);
    chk(st_done == 1'b1, "R6 done on time", int'(st_done), 1);
  endtask

  task automatic send_byte(logic [7:0] d, bit start, bit want, bit poke);
    int b0, s0;
    b0 = nbytes; s0 = nstarts; ack_want = want;
    run_op(d, exp_quarters(start, 1'b0), poke);
    chk(nbytes == b0 + 1, "R4 one byte", nbytes - b0, 1);
    chk(last_byte == d, "R9 byte MSB first", int'(last_byte), int'(d));
    chk(st_ack == exp_ack(want), "R5 ack flag", int'(st_ack), int'(exp_ack(want)));
    chk(nstarts == s0 + int'(start), "R2 start count", nstarts - s0, int'(start));
    chk(scl_pull_low && !sda_pull_low, "R4 bus held", {scl_pull_low, sda_pull_low}, 2);
  endtask

  task automatic send_stop(bit held);
    int p0;
    p0 = nstops;
    run_op($urandom, exp_quarters(1'b0, 1'b1), 1'b0);
    chk(nstops == p0 + int'(held), "R3 stop count", nstops - p0, int'(held));
    chk(!scl_pull_low && !sda_pull_low, "R3 lines released", {scl_pull_low, sda_pull_low}, 0);
    chk(ctl_q[2] == 1'b0, "R8 stop bit cleared", int'(ctl_q), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, p0, b0, nb;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nstarts = 0; nstops = 0; nbytes = 0; bitcnt = 0;

    chk(st_done == 1'b1 && st_ack == 1'b0, "R1 flags", {st_done, st_ack}, 2);
    chk(ctl_q == 3'd0, "R1 control", int'(ctl_q), 0);
    chk(!scl_pull_low && !sda_pull_low, "R1 lines", {scl_pull_low, sda_pull_low}, 0);

    // R7: enable clear, then plain byte on a free bus
    wr_ctl(3'b010);
    wr_tx(8'hA5); repeat (3) @(negedge clk);
    chk(st_done && !scl_pull_low && !sda_pull_low, "R7 disabled write", {st_done, scl_pull_low, sda_pull_low}, 4);
    wr_ctl(3'b001);
    wr_tx(8'hA5); repeat (3) @(negedge clk);
    chk(st_done && !scl_pull_low && !sda_pull_low, "R7 unowned byte", {st_done, scl_pull_low, sda_pull_low}, 4);

    // R3: stop on a free bus drives nothing
    wr_ctl(3'b101);
    send_stop(1'b0);

    // R2 directed write with busy poke (R7)
    wr_ctl(3'b011);
    send_byte(8'hA0, 1'b1, 1'b1, 1'b1);
    chk(ctl_q == 3'b001, "R8 start bit cleared", int'(ctl_q), 1);
    send_byte(8'h00, 1'b0, 1'b0, 1'b1);
    send_byte(8'hFF, 1'b0, 1'b1, 1'b0);

    // R2 repeated start on held bus
    wr_ctl(3'b011);
    send_byte(8'hA1, 1'b1, 1'b1, 1'b0);

    // R10: disable while held
    p0 = nstops; s0 = nstarts;
    wr_ctl(3'b000); repeat (2) @(negedge clk);
    chk(!scl_pull_low && !sda_pull_low, "R10 released", {scl_pull_low, sda_pull_low}, 0);
    chk(nstops == p0 && nstarts == s0, "R10 no condition", nstops - p0, 0);
    wr_ctl(3'b001);
    b0 = nbytes;
    wr_tx(8'h3C); repeat (3) @(negedge clk);
    chk(st_done && nbytes == b0 && !scl_pull_low, "R10 bus not held", nbytes - b0, 0);

    // R8: start and stop together, start wins
    wr_ctl(3'b111);
    p0 = nstops;
    send_byte(8'h52, 1'b1, 1'b0, 1'b0);
    chk(ctl_q == 3'b101, "R8 stop kept", int'(ctl_q), 5);
    chk(nstops == p0, "R8 no stop yet", nstops - p0, 0);
    send_stop(1'b1);

    // random page writes
    for (int t = 0; t < 20; t++) begin
      wr_ctl(3'b011);
      send_byte({7'($urandom), 1'b0}, 1'b1, 1'($urandom), 1'($urandom));
      nb = 1 + ($urandom % 4);
      for (int i = 0; i < nb; i++)
        send_byte(8'($urandom), 1'b0, 1'($urandom), 1'($urandom));
      wr_ctl(3'b101);
      send_stop(1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule